// File: doc/BRIEF.md
# Operand-Two Barrel Shifter

This block is the combinational front end that forms the second operand of a 32-bit data-processing operation. It sits between the register read stage and the ALU. A source select picks between two ways of building the operand. In the first, a short constant carried in the instruction is rotated right by an even amount. In the second, a register value is shifted by one of four shift kinds, by an amount that comes either from a 5-bit field in the instruction or from the low byte of a second register.

The block also returns the shifter carry, which is the last bit shifted out. The ALU uses this carry when it updates its flags for logical operations. The block raises an illegal-instruction flag when the shift amount would be read from the program counter. Decoding, register reads and the ALU itself sit outside the block. The block has no clock and no state.

Top module: `opnd2_shifter`

## Requirements
- R1: With `src_sel_i`=0 (constant mode), `opnd_o` is `imm8_i` zero-extended to 32 bits and rotated right by twice `rot_i`, so rotations run from 0 to 30 in steps of two.
- R2: In constant mode, `carry_o` equals `carry_i` when `rot_i` is 0, and otherwise equals bit 31 of `opnd_o`.
- R3: With `src_sel_i`=1 (register mode), `kind_i` selects the shift: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. When `amt_from_reg_i`=0, the amount is `shamt_i` taken exactly as encoded (0 to 31).
- R4: When `amt_from_reg_i`=1, the amount is `rs_val_i[7:0]`, and bits [31:8] of `rs_val_i` have no effect.
- R5: In register mode, an amount of 0 from either source passes `rm_val_i` through unchanged and gives `carry_o` = `carry_i`.
- R6: For a logical shift by 32, the result is 0. The carry is `rm_val_i[0]` for a left shift and `rm_val_i[31]` for a right shift. For a logical shift by more than 32, both the result and the carry are 0.
- R7: For an arithmetic right shift by 32 or more, every result bit and the carry equal `rm_val_i[31]`.
- R8: For rotate right, the amount is taken modulo 32. A nonzero multiple of 32 returns `rm_val_i` unchanged, with the carry equal to `rm_val_i[31]`.
- R9: For a nonzero amount below 32, the carry is the last bit shifted out: `rm_val_i[32-n]` for a left shift, `rm_val_i[n-1]` for a logical or arithmetic right shift, and bit 31 of the result for a rotate.
- R10: `illegal_o` is 1 exactly when register mode, `amt_from_reg_i`=1 and `rs_is_pc_i`=1 hold together. While it is 1, `opnd_o` is 0 and `carry_o` equals `carry_i`.
- R11: In constant mode, `rm_val_i`, `rs_val_i`, `shamt_i`, `kind_i`, `amt_from_reg_i` and `rs_is_pc_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_sel_i | input | 1 | 0 selects the rotated constant, 1 selects the shifted register |
| kind_i | input | 2 | Shift kind used in register mode |
| imm8_i | input | 8 | Constant to rotate in constant mode |
| rot_i | input | 4 | Half of the constant's rotate amount |
| shamt_i | input | 5 | Shift amount taken from the instruction |
| amt_from_reg_i | input | 1 | 1 takes the amount from `rs_val_i[7:0]` |
| rm_val_i | input | 32 | Register value to be shifted |
| rs_val_i | input | 32 | Register value that supplies the shift amount |
| rs_is_pc_i | input | 1 | The amount register is the program counter |
| carry_i | input | 1 | Current carry flag |
| opnd_o | output | 32 | Second operand |
| carry_o | output | 1 | Shifter carry-out |
| illegal_o | output | 1 | The amount register is the program counter |

## Verification
The bench goes after the amount boundaries, because that is where shifters usually go wrong. It drives amounts of 0, 31, 32 and 33, large values such as 200, and values whose upper bits are set but whose low byte is small. A design that treated an encoded 0 as 32 would return 0 or sign fill when it should pass the value through. A design that used all 32 bits of the amount register would zero results that should have been shifted. A design that wrapped logical amounts modulo 32 would return shifted data where zero is expected.

The bench also checks the carry when no shift happens, and the carry for shifts of exactly 32, since an off-by-one there picks the neighbouring bit. It drives a program-counter amount register in each mode, to catch a design that flags it in constant mode or lets shifted data leak out while the flag is raised.

// File: rtl/bs_pkg.sv
`timescale 1ns/1ps
package bs_pkg;

  localparam int unsigned OPND_W  = 32;
  localparam int unsigned CONST_W = 8;
  localparam int unsigned ROT_W   = 4;
  localparam int unsigned SHAMT_W = 5;
  localparam int unsigned RSAMT_W = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic {
    SRC_CONST = 1'b0,
    SRC_REG   = 1'b1
  } opnd_src_e;

endpackage

// File: rtl/bs_const_rotator.sv
`timescale 1ns/1ps
module bs_const_rotator #(
  parameter int unsigned DATA_W  = bs_pkg::OPND_W,
  parameter int unsigned CONST_W = bs_pkg::CONST_W,
  parameter int unsigned ROT_W   = bs_pkg::ROT_W
) (
  input  logic [CONST_W-1:0] const_i,
  input  logic [ROT_W-1:0]   rot_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  value_o,
  output logic               carry_o
);

  localparam int unsigned RAMT_W = ROT_W + 1;

  function automatic logic [DATA_W-1:0] rot_right(input logic [DATA_W-1:0] v,
                                                  input logic [RAMT_W-1:0] n);
    rot_right = (v >> n) | (v << (DATA_W - n));
  endfunction

  logic [RAMT_W-1:0] rot_amt;
  logic [DATA_W-1:0] const_ext;
  logic              no_rot;

  assign rot_amt   = {rot_i, 1'b0};
  assign const_ext = DATA_W'(const_i);
  assign no_rot    = (rot_i == '0);

  always_comb begin
    value_o = rot_right(const_ext, rot_amt);
    carry_o = no_rot ? carry_i : value_o[DATA_W-1];
  end

  always_comb begin
    if (!$isunknown({const_i, rot_i, carry_i})) begin
      AST_CONST_ONES_KEPT: assert ($countones(value_o) == $countones(const_i)); // R1
      AST_CONST_NOROT_PASS: assert (!no_rot || (value_o == const_ext && carry_o == carry_i)); // R2
    end
  end

endmodule

// File: rtl/bs_amount_select.sv
`timescale 1ns/1ps
module bs_amount_select #(
  parameter int unsigned DATA_W  = bs_pkg::OPND_W,
  parameter int unsigned SHAMT_W = bs_pkg::SHAMT_W,
  parameter int unsigned RSAMT_W = bs_pkg::RSAMT_W
) (
  input  logic               from_reg_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic               rs_is_pc_i,
  output logic [RSAMT_W-1:0] amt_o,
  output logic               pc_amt_o
);

  logic [RSAMT_W-1:0] field_amt;
  logic [RSAMT_W-1:0] reg_amt;

  assign field_amt = RSAMT_W'(shamt_i);
  assign reg_amt   = rs_val_i[RSAMT_W-1:0];
  assign amt_o     = from_reg_i ? reg_amt : field_amt;
  assign pc_amt_o  = from_reg_i & rs_is_pc_i;

  always_comb begin
    if (!$isunknown({from_reg_i, shamt_i, rs_val_i, rs_is_pc_i})) begin
      AST_FIELD_AMT_RANGE: assert (from_reg_i || (amt_o < RSAMT_W'(1 << SHAMT_W))); // R3
      AST_PC_ONLY_FROM_REG: assert (!pc_amt_o || from_reg_i); // R10
    end
  end

endmodule

// File: rtl/bs_reg_shifter.sv
`timescale 1ns/1ps
module bs_reg_shifter #(
  parameter int unsigned DATA_W  = bs_pkg::OPND_W,
  parameter int unsigned RSAMT_W = bs_pkg::RSAMT_W
) (
  input  logic [DATA_W-1:0]    rm_i,
  input  logic [RSAMT_W-1:0]   amt_i,
  input  bs_pkg::shift_kind_e  kind_i,
  input  logic                 carry_i,
  output logic [DATA_W-1:0]    value_o,
  output logic                 carry_o
);

  import bs_pkg::*;

  localparam int unsigned STG = $clog2(DATA_W);
  localparam int unsigned MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] stage_step(input logic [DATA_W-1:0] v,
                                                   input shift_kind_e k,
                                                   input int unsigned n);
    case (k)
      SH_LSL:  stage_step = v << n;
      SH_LSR:  stage_step = v >> n;
      SH_ASR:  stage_step = DATA_W'($signed(v) >>> n);
      default: stage_step = (v >> n) | (v << (DATA_W - n));
    endcase
  endfunction

  logic [STG-1:0]    amt_low;
  logic              amt_zero;
  logic              low_zero;
  logic              amt_big;
  logic              over_w;
  logic              exact_w;
  logic [DATA_W-1:0] net_out;
  logic [DATA_W-1:0] left_tap;
  logic [DATA_W-1:0] right_tap;

  assign amt_low  = amt_i[STG-1:0];
  assign amt_zero = (amt_i == '0);
  assign low_zero = (amt_low == '0);

  generate
    if (RSAMT_W > STG) begin : g_high_bits
      assign amt_big = |amt_i[RSAMT_W-1:STG];
    end else begin : g_no_high_bits
      assign amt_big = 1'b0;
    end
  endgenerate

  assign over_w  = !amt_zero && (amt_big || low_zero);
  assign exact_w = (amt_i == RSAMT_W'(DATA_W));

  always_comb begin
    net_out = rm_i;
    for (int i = 0; i < int'(STG); i++) begin
      if (amt_low[i]) net_out = stage_step(net_out, kind_i, 1 << i);
    end
  end

  assign left_tap  = rm_i << (amt_low - 1'b1);
  assign right_tap = rm_i >> (amt_low - 1'b1);

  always_comb begin
    if (amt_zero) begin
      value_o = rm_i;
    end else if (over_w) begin
      case (kind_i)
        SH_LSL, SH_LSR: value_o = '0;
        SH_ASR:         value_o = {DATA_W{rm_i[MSB]}};
        default:        value_o = net_out;
      endcase
    end else begin
      value_o = net_out;
    end
  end

  always_comb begin
    if (amt_zero) begin
      carry_o = carry_i;
    end else begin
      case (kind_i)
        SH_LSL:  carry_o = over_w ? (exact_w & rm_i[0])   : left_tap[MSB];
        SH_LSR:  carry_o = over_w ? (exact_w & rm_i[MSB]) : right_tap[0];
        SH_ASR:  carry_o = over_w ? rm_i[MSB]             : right_tap[0];
        default: carry_o = value_o[MSB];
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({rm_i, amt_i, kind_i, carry_i})) begin
      AST_ZERO_AMT_PASS: assert (!amt_zero || (value_o == rm_i && carry_o == carry_i)); // R5
      AST_LOGICAL_FLUSH: assert (!(over_w && (kind_i == SH_LSL || kind_i == SH_LSR)) || value_o == '0); // R6
      AST_ASR_FILL: assert (!(over_w && kind_i == SH_ASR) ||
                            $countones(value_o) == (rm_i[MSB] ? DATA_W : 0)); // R7
      AST_ROR_ONES_KEPT: assert (kind_i != SH_ROR || $countones(value_o) == $countones(rm_i)); // R8
    end
  end

endmodule

// File: rtl/opnd2_shifter.sv
`timescale 1ns/1ps
module opnd2_shifter #(
  parameter int unsigned DATA_W  = bs_pkg::OPND_W,
  parameter int unsigned CONST_W = bs_pkg::CONST_W,
  parameter int unsigned ROT_W   = bs_pkg::ROT_W,
  parameter int unsigned SHAMT_W = bs_pkg::SHAMT_W,
  parameter int unsigned RSAMT_W = bs_pkg::RSAMT_W
) (
  input  logic               src_sel_i,
  input  logic [1:0]         kind_i,
  input  logic [CONST_W-1:0] imm8_i,
  input  logic [ROT_W-1:0]   rot_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               amt_from_reg_i,
  input  logic [DATA_W-1:0]  rm_val_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic               rs_is_pc_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  opnd_o,
  output logic               carry_o,
  output logic               illegal_o
);

  import bs_pkg::*;

  opnd_src_e          src;
  shift_kind_e        kind;
  logic [DATA_W-1:0]  const_val;
  logic               const_carry;
  logic [RSAMT_W-1:0] shift_amt;
  logic               pc_amt;
  logic [DATA_W-1:0]  reg_val;
  logic               reg_carry;

  assign src  = opnd_src_e'(src_sel_i);
  assign kind = shift_kind_e'(kind_i);

  bs_const_rotator #(.DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W)) u_const (
    .const_i (imm8_i),
    .rot_i   (rot_i),
    .carry_i (carry_i),
    .value_o (const_val),
    .carry_o (const_carry)
  );

  bs_amount_select #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .RSAMT_W(RSAMT_W)) u_amt (
    .from_reg_i (amt_from_reg_i),
    .shamt_i    (shamt_i),
    .rs_val_i   (rs_val_i),
    .rs_is_pc_i (rs_is_pc_i),
    .amt_o      (shift_amt),
    .pc_amt_o   (pc_amt)
  );

  bs_reg_shifter #(.DATA_W(DATA_W), .RSAMT_W(RSAMT_W)) u_shift (
    .rm_i    (rm_val_i),
    .amt_i   (shift_amt),
    .kind_i  (kind),
    .carry_i (carry_i),
    .value_o (reg_val),
    .carry_o (reg_carry)
  );

  always_comb begin
    illegal_o = (src == SRC_REG) && pc_amt;
    if (illegal_o) begin
      opnd_o  = '0;
      carry_o = carry_i;
    end else if (src == SRC_CONST) begin
      opnd_o  = const_val;
      carry_o = const_carry;
    end else begin
      opnd_o  = reg_val;
      carry_o = reg_carry;
    end
  end

  always_comb begin
    if (!$isunknown({src_sel_i, amt_from_reg_i, rs_is_pc_i, carry_i, opnd_o})) begin
      AST_ILLEGAL_QUIET: assert (!illegal_o || (opnd_o == '0 && carry_o == carry_i)); // R10
      AST_CONST_NEVER_ILLEGAL: assert (src_sel_i || !illegal_o); // R11
      AST_CONST_WIDTH: assert (src_sel_i || $countones(opnd_o) <= CONST_W); // R1
    end
  end

endmodule

// File: tb/opnd2_shifter_bench.sv
`timescale 1ns/1ps
module opnd2_shifter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_sel;
  logic [1:0]  kind;
  logic [7:0]  imm8;
  logic [3:0]  rot;
  logic [4:0]  shamt;
  logic        from_reg;
  logic [31:0] rm_val;
  logic [31:0] rs_val;
  logic        rs_pc;
  logic        cin;
  logic [31:0] opnd;
  logic        cout;
  logic        illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  opnd2_shifter u_opnd2_shifter (
    .src_sel_i      (src_sel),
    .kind_i         (kind),
    .imm8_i         (imm8),
    .rot_i          (rot),
    .shamt_i        (shamt),
    .amt_from_reg_i (from_reg),
    .rm_val_i       (rm_val),
    .rs_val_i       (rs_val),
    .rs_is_pc_i     (rs_pc),
    .carry_i        (cin),
    .opnd_o         (opnd),
    .carry_o        (cout),
    .illegal_o      (illegal)
  );

  // Reference model written from the requirements with wide-vector arithmetic.
  task automatic model(output logic [31:0] ev, output logic ec, output logic ei);
    int n;
    logic [63:0] w;
    ei = src_sel && from_reg && rs_pc;
    if (ei) begin
      ev = 32'h0; ec = cin;
    end else if (!src_sel) begin
      ev = {24'h0, imm8};
      for (int i = 0; i < 2 * int'(rot); i++) ev = {ev[0], ev[31:1]};
      ec = (rot == 4'd0) ? cin : ev[31];
    end else begin
      n = from_reg ? int'(rs_val[7:0]) : int'(shamt);
      if (n == 0) begin
        ev = rm_val; ec = cin;
      end else begin
        case (kind)
          2'b00: begin
            w = {32'h0, rm_val} << n;
            ev = w[31:0]; ec = (n <= 32) ? w[32] : 1'b0;
          end
          2'b01: begin
            w = {rm_val, 32'h0} >> n;
            ev = w[63:32]; ec = (n <= 32) ? w[31] : 1'b0;
          end
          2'b10: begin
            if (n >= 32) begin
              ev = {32{rm_val[31]}}; ec = rm_val[31];
            end else begin
              w = 64'($signed({rm_val, 32'h0}) >>> n);
              ev = w[63:32]; ec = w[31];
            end
          end
          default: begin
            ev = rm_val;
            for (int i = 0; i < n % 32; i++) ev = {ev[0], ev[31:1]};
            ec = ev[31];
          end
        endcase
      end
    end
  endtask

  task automatic check(input string tag);
    logic [31:0] ev;
    logic ec, ei;
    @(negedge clk);
    model(ev, ec, ei);
    n_cmp++;
    if (opnd !== ev || cout !== ec || illegal !== ei) begin
      n_bad++;
      $display("FAIL %s: got opnd=%h carry=%b illegal=%b expected opnd=%h carry=%b illegal=%b",
               tag, opnd, cout, illegal, ev, ec, ei);
    end
  endtask

  task automatic drive_const(input logic [7:0] c, input logic [3:0] r, input logic ci, input string tag);
    @(posedge clk);
    src_sel = 1'b0; imm8 = c; rot = r; cin = ci;
    check(tag);
  endtask

  task automatic drive_reg(input logic [1:0] k, input logic fr, input logic [4:0] sa,
                           input logic [31:0] rm, input logic [31:0] rs, input logic pc,
                           input logic ci, input string tag);
    @(posedge clk);
    src_sel = 1'b1; kind = k; from_reg = fr; shamt = sa;
    rm_val = rm; rs_val = rs; rs_pc = pc; cin = ci;
    check(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: got no end of run expected end within limit");
    summary();
  end

  initial begin
    src_sel = 0; kind = 0; imm8 = 0; rot = 0; shamt = 0; from_reg = 0;
    rm_val = 0; rs_val = 0; rs_pc = 0; cin = 0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    check("R1 idle all-zero inputs");

    drive_const(8'hFF, 4'd4, 1'b0, "R1 rotate by 8");
    drive_const(8'h3F, 4'd0, 1'b1, "R2 no rotation keeps carry");
    drive_const(8'h01, 4'd1, 1'b1, "R2 carry from bit 31 clear");
    drive_const(8'h80, 4'd15, 1'b0, "R1 rotate by 30");

    drive_reg(2'b00, 1'b0, 5'd4, 32'h8000_000F, 32'h0, 1'b0, 1'b0, "R3 LSL field 4");
    drive_reg(2'b01, 1'b0, 5'd4, 32'hF000_0018, 32'h0, 1'b0, 1'b0, "R3 LSR field 4");
    drive_reg(2'b10, 1'b0, 5'd4, 32'h8000_0008, 32'h0, 1'b0, 1'b0, "R3 ASR field 4");
    drive_reg(2'b11, 1'b0, 5'd8, 32'h1234_5680, 32'h0, 1'b0, 1'b0, "R3 ROR field 8");
    drive_reg(2'b01, 1'b0, 5'd0, 32'hDEAD_BEEF, 32'h0, 1'b0, 1'b1, "R5 encoded zero is no shift");
    drive_reg(2'b10, 1'b0, 5'd31, 32'h8000_0000, 32'h0, 1'b0, 1'b0, "R9 ASR field 31");

    drive_reg(2'b00, 1'b1, 5'd0, 32'h0000_00F1, 32'hFFFF_FF04, 1'b0, 1'b0, "R4 upper rs bits ignored");
    drive_reg(2'b11, 1'b1, 5'd0, 32'hCAFE_F00D, 32'h0000_0100, 1'b0, 1'b1, "R4 R5 low byte zero");
    drive_reg(2'b00, 1'b1, 5'd0, 32'h0000_0001, 32'd32, 1'b0, 1'b0, "R6 LSL by 32");
    drive_reg(2'b00, 1'b1, 5'd0, 32'hFFFF_FFFF, 32'd33, 1'b0, 1'b1, "R6 LSL by 33");
    drive_reg(2'b01, 1'b1, 5'd0, 32'h8000_0000, 32'd32, 1'b0, 1'b0, "R6 LSR by 32");
    drive_reg(2'b01, 1'b1, 5'd0, 32'hFFFF_FFFF, 32'd200, 1'b0, 1'b1, "R6 LSR by 200");
    drive_reg(2'b10, 1'b1, 5'd0, 32'h8000_1234, 32'd40, 1'b0, 1'b0, "R7 ASR negative by 40");
    drive_reg(2'b10, 1'b1, 5'd0, 32'h7FFF_FFFF, 32'd255, 1'b0, 1'b1, "R7 ASR positive by 255");
    drive_reg(2'b11, 1'b1, 5'd0, 32'h8765_4321, 32'd32, 1'b0, 1'b0, "R8 ROR by 32");
    drive_reg(2'b11, 1'b1, 5'd0, 32'h0000_0010, 32'd36, 1'b0, 1'b0, "R8 ROR by 36");
    drive_reg(2'b00, 1'b1, 5'd0, 32'h4000_0000, 32'd2, 1'b0, 1'b0, "R9 LSL carry bit 30");
    drive_reg(2'b01, 1'b1, 5'd0, 32'h0000_0003, 32'd31, 1'b0, 1'b0, "R9 LSR by 31");

    drive_reg(2'b00, 1'b1, 5'd3, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b1, "R10 amount register is pc");
    drive_reg(2'b01, 1'b0, 5'd3, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0, "R10 pc flag with field amount");
    @(posedge clk);
    src_sel = 1'b0; imm8 = 8'h5A; rot = 4'd2; cin = 1'b1;
    from_reg = 1'b1; rs_pc = 1'b1; rm_val = 32'hFFFF_FFFF; rs_val = 32'd7; kind = 2'b01; shamt = 5'd9;
    check("R10 R11 constant mode with pc flag");
    @(posedge clk);
    rm_val = 32'h1357_9BDF; rs_val = 32'hFFFF_FFFF; kind = 2'b10; from_reg = 1'b0; rs_pc = 1'b0;
    check("R11 register inputs ignored in constant mode");

    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      src_sel  = ($urandom % 4) != 0;
      kind     = 2'($urandom);
      imm8     = 8'($urandom);
      rot      = 4'($urandom);
      shamt    = 5'($urandom);
      from_reg = 1'($urandom);
      rm_val   = $urandom;
      case ($urandom % 4)
        0: rs_val = $urandom % 40;
        1: rs_val = {$urandom % 32'h0100_0000, 8'd32};
        default: rs_val = $urandom;
      endcase
      rs_pc = ($urandom % 8) == 0;
      cin   = 1'($urandom);
      check("R3 R9 random vector");
    end

    summary();
  end

endmodule